// File: doc/BRIEF.md
# ADC Power and Channel Sequencer

This block runs on a slow always-on clock. It controls an external multi-channel ADC. It drives a power-down line and a one-hot channel select. The ADC answers each select with a one-cycle data-valid strobe and a sample word. The sequencer waits for that strobe, stores the sample in a per-channel slot and moves on to the next channel in ascending order. After the highest channel it raises a one-cycle done pulse. At that moment the output bus holds one fresh sample per channel.

There are two modes. In continuous mode the converter is powered once and the scan wraps from the highest channel back to channel 0 without stopping. In low-power mode the converter is powered down after every scan and sleeps for a configured number of cycles. It then wakes, waits out a configured settle delay and scans again. The settle delay, the sleep length and the mode are plain configuration inputs. Scanning begins when the enable input is seen high in the idle state. If enable is low when a scan ends, the block goes back to idle with the converter powered down.

Top module: `adc_seq_top`

## Requirements
- R1: A synchronous active-high reset forces `adc_pd` high, `adc_sel` to zero, `scan_done` low and every slot of `scan_data` to zero. The block then stays powered down for as long as `enable` is low.
- R2: `adc_sel` is all-zero or one-hot in every cycle. Neither `adc_pd` nor `adc_sel` is ever unknown after reset.
- R3: Each time `adc_pd` falls, the first channel select rises exactly `pwrup_cycles`+1 clock cycles later, and no select is high in between.
- R4: Once a select is high, it stays unchanged until `adc_valid` is seen. It then returns to zero for at least one cycle before any other select rises.
- R5: Each scan starts at channel 0 after power-up and selects channels in strictly ascending index order. Channel `NUM_CH`-1 is the last channel of a scan.
- R6: In low-power mode, `adc_pd` stays high for exactly `sleep_cycles` clock cycles from its rising edge to its falling edge. A `sleep_cycles` value of 0 is treated as 1.
- R7: In low-power mode, `adc_pd` rises again 1 to 4 cycles after the highest channel's select falls. This design uses 1 cycle.
- R8: In continuous mode, `adc_pd` stays low while `enable` is high, and the scan wraps from channel `NUM_CH`-1 to channel 0 with a one-cycle gap.
- R9: A slot is written only on a cycle where `adc_valid` is high, `adc_pd` is low and that slot's channel is selected. A strobe while powered down or while no channel is selected leaves `scan_data` unchanged.
- R10: `scan_done` is high for exactly one cycle, in the cycle after the highest channel's strobe. In that same cycle `scan_data` holds all of that scan's samples. Channel i occupies bits [i*`DATA_W` +: `DATA_W`].
- R11: `enable` is read only in the idle state and at the end of a scan. If it is low at the end of a scan, `adc_pd` rises and stays high, and `adc_sel` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start scanning / keep scanning |
| low_power | input | 1 | 1 = sleep between scans, 0 = continuous |
| pwrup_cycles | input | CNT_W | Settle delay after power-up, minus one |
| sleep_cycles | input | CNT_W | Power-down length in low-power mode |
| adc_valid | input | 1 | Sample strobe from the converter |
| adc_data | input | DATA_W | Sample word from the converter |
| adc_pd | output | 1 | Converter power-down |
| adc_sel | output | NUM_CH | One-hot channel select |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| scan_data | output | NUM_CH*DATA_W | Latest sample of every channel |

## Verification
The hardest cases to reach are strobes that must be ignored. These are a data-valid pulse while the converter sleeps, and one during the empty cycles of the settle window. A correct converter never sends either. The bench's converter model therefore injects one junk strobe with a distinct word into each powered-down stretch and into each gap with no select. It compares `scan_data` on the following cycle with a snapshot. The settle and sleep timings are also run at their edge values: a settle of zero and sleep lengths of 1 and 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_GAP    = 3'd3,
    ST_SLEEP  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/adc_seq_count.sv
module adc_seq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (clr)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_seq_onehot.sv
module adc_seq_onehot #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  vec
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign vec[i] = (idx == IW'(i));
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              low_power,
  input  logic [CNT_W-1:0]  pwrup_cycles,
  input  logic [CNT_W-1:0]  sleep_cycles,
  input  logic              adc_valid,
  output logic              adc_pd,
  output logic [NUM_CH-1:0] adc_sel
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

  seq_state_e        state;
  logic              pd_q;
  logic [NUM_CH-1:0] sel_q;
  logic [IDX_W-1:0]  idx_q, nxt_idx, dec_idx;
  logic [NUM_CH-1:0] dec_vec;
  logic [CNT_W-1:0]  cnt, sleep_last;
  logic              cnt_inc, cnt_clr, settle_hit, sleep_hit, wrap;

  always_comb begin
    wrap       = (idx_q == LAST_IDX);
    nxt_idx    = wrap ? '0 : idx_q + 1'b1;
    dec_idx    = (state == ST_GAP) ? nxt_idx : '0;
    sleep_last = (sleep_cycles == '0) ? '0 : sleep_cycles - 1'b1;
    settle_hit = (state == ST_SETTLE) && (cnt == pwrup_cycles);
    sleep_hit  = (state == ST_SLEEP) && (cnt == sleep_last);
    cnt_inc    = (state == ST_SETTLE) || (state == ST_SLEEP);
    cnt_clr    = rst || !cnt_inc || settle_hit || sleep_hit;
  end

  adc_seq_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .clr(cnt_clr), .inc(cnt_inc), .count(cnt)
  );

  adc_seq_onehot #(.N(NUM_CH), .IW(IDX_W)) u_dec (
    .idx(dec_idx), .vec(dec_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pd_q  <= 1'b1;
      sel_q <= '0;
      idx_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (enable) begin
          pd_q  <= 1'b0;
          idx_q <= '0;
          state <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_hit) begin
          sel_q <= dec_vec;
          state <= ST_WAIT;
        end
        ST_WAIT: if (adc_valid) begin
          sel_q <= '0;
          state <= ST_GAP;
        end
        ST_GAP: begin
          if (wrap && !enable) begin
            pd_q  <= 1'b1;
            idx_q <= '0;
            state <= ST_IDLE;
          end else if (wrap && low_power) begin
            pd_q  <= 1'b1;
            idx_q <= '0;
            state <= ST_SLEEP;
          end else begin
            idx_q <= nxt_idx;
            sel_q <= dec_vec;
            state <= ST_WAIT;
          end
        end
        ST_SLEEP: if (sleep_hit) begin
          pd_q  <= 1'b0;
          state <= ST_SETTLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_pd  = pd_q;
  assign adc_sel = sel_q;

  // Checker-only settle timer: cycles from power-down release to first select
  logic [CNT_W:0] chk_settle;
  logic           chk_arm;
  always_ff @(posedge clk) begin
    if (rst || pd_q) begin
      chk_settle <= '0;
      chk_arm    <= 1'b1;
    end else if (|sel_q) begin
      chk_arm    <= 1'b0;
    end else if (chk_arm) begin
      chk_settle <= chk_settle + 1'b1;
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_q));
  // R3
  settle_delay_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(|sel_q) && chk_arm) |-> (chk_settle == ({1'b0, pwrup_cycles} + 1'b1)));
  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|sel_q) && !adc_valid) |=> $stable(sel_q));
  // R4
  sel_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((|sel_q) && adc_valid) |=> (sel_q == '0));
  // R7
  lp_reenter_chk: assert property (@(posedge clk) disable iff (rst)
    (low_power && $fell(sel_q[NUM_CH-1])) |=> pd_q);
  // R8
  cont_power_chk: assert property (@(posedge clk) disable iff (rst)
    (!low_power && enable && !pd_q) |=> !pd_q);
  for (genvar i = 1; i < NUM_CH; i++) begin : g_order
    // R5
    scan_order_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sel_q[i]) |-> $past(sel_q[i-1], 2));
  end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adc_pd,
  input  logic                     adc_valid,
  input  logic [NUM_CH-1:0]        adc_sel,
  input  logic [DATA_W-1:0]        adc_data,
  output logic [NUM_CH*DATA_W-1:0] scan_data,
  output logic                     scan_done
);
  logic take;
  assign take = adc_valid && !adc_pd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                  slot_q <= '0;
      else if (take && adc_sel[i]) slot_q <= adc_data;
    end
    assign scan_data[i*DATA_W +: DATA_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) scan_done <= 1'b0;
    else     scan_done <= take && adc_sel[NUM_CH-1];
  end

  // R9
  pd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    adc_pd |=> $stable(scan_data));
  // R9
  nosel_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_sel == '0) |=> $stable(scan_data));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     low_power,
  input  logic [CNT_W-1:0]         pwrup_cycles,
  input  logic [CNT_W-1:0]         sleep_cycles,
  input  logic                     adc_valid,
  input  logic [DATA_W-1:0]        adc_data,
  output logic                     adc_pd,
  output logic [NUM_CH-1:0]        adc_sel,
  output logic                     scan_done,
  output logic [NUM_CH*DATA_W-1:0] scan_data
);
  adc_seq_fsm #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .low_power(low_power),
    .pwrup_cycles(pwrup_cycles), .sleep_cycles(sleep_cycles),
    .adc_valid(adc_valid), .adc_pd(adc_pd), .adc_sel(adc_sel)
  );

  adc_seq_capture #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .adc_pd(adc_pd), .adc_valid(adc_valid),
    .adc_sel(adc_sel), .adc_data(adc_data),
    .scan_data(scan_data), .scan_done(scan_done)
  );
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 10;
  localparam int CNT_W  = 8;
  localparam int VW     = NUM_CH * DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic              low_power = 1'b0;
  logic [CNT_W-1:0]  pwrup_cycles = '0;
  logic [CNT_W-1:0]  sleep_cycles = 8'd1;
  logic              adc_valid = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              adc_pd;
  logic [NUM_CH-1:0] adc_sel;
  logic              scan_done;
  logic [VW-1:0]     scan_data;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  bit finished = 0;
  logic [VW-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  adc_seq_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .low_power(low_power),
    .pwrup_cycles(pwrup_cycles), .sleep_cycles(sleep_cycles),
    .adc_valid(adc_valid), .adc_data(adc_data), .adc_pd(adc_pd),
    .adc_sel(adc_sel), .scan_done(scan_done), .scan_data(scan_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Converter model / driver: answers selects, injects junk strobes, records expected scans
  initial begin
    int resp = 0;
    int waitc = 0;
    bit served = 0;
    bit junk_done = 0;
    bit junk_chk = 0;
    logic [VW-1:0] vec = '0;
    logic [VW-1:0] snap = '0;
    forever begin
      @(negedge clk);
      if (junk_chk) begin
        // R9: junk strobe must leave the slots untouched
        chk(scan_data == snap, "R9", longint'(scan_data[31:0]), longint'(snap[31:0]));
        junk_chk = 0;
      end
      adc_valid = 1'b0;
      adc_data  = DATA_W'(resp * 13 + 1);
      if (rst) begin
        served = 0; waitc = 0; junk_done = 0;
      end else if (adc_sel == '0) begin
        served = 0; waitc = 0;
        if (!junk_done) begin
          adc_valid = 1'b1;
          adc_data  = '1;
          snap = scan_data;
          junk_chk = 1;
          junk_done = 1;
        end
      end else if (!served && !adc_pd) begin
        int ch = 0;
        for (int i = 0; i < NUM_CH; i++) if (adc_sel[i]) ch = i;
        junk_done = 0;
        if (waitc >= (ch + resp) % 3) begin
          logic [DATA_W-1:0] val;
          val = DATA_W'((resp * 37 + ch * 11 + 5) % 1000);
          adc_valid = 1'b1;
          adc_data  = val;
          vec[ch*DATA_W +: DATA_W] = val;
          served = 1;
          resp++;
          if (ch == NUM_CH - 1) exp_q.push_back(vec);
        end else begin
          waitc++;
        end
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [NUM_CH-1:0] prev_sel = '0;
    logic prev_pd = 1'b1, prev_valid = 1'b0, prev_done = 1'b0, prev_en = 1'b0;
    int settle_t = 0, sleep_t = 0, lp_t = 0, exp_next = 0;
    bit settle_arm = 0, sleep_arm = 0, lp_arm = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        prev_sel = '0; prev_pd = 1'b1; prev_valid = 0; prev_done = 0; prev_en = 0;
        settle_arm = 0; sleep_arm = 0; lp_arm = 0; exp_next = 0;
        continue;
      end
      // R2
      if (!$onehot0(adc_sel) || $isunknown({adc_pd, adc_sel}))
        chk(0, "R2", longint'(adc_sel), 0);
      // R10 pulse width and content
      if (prev_done && scan_done) chk(0, "R10", 1, 0);
      if (scan_done) begin
        done_seen++;
        if (exp_q.size() == 0) chk(0, "R10", 1, 0);
        else begin
          logic [VW-1:0] e;
          e = exp_q.pop_front();
          for (int i = 0; i < NUM_CH; i++)
            chk(scan_data[i*DATA_W +: DATA_W] == e[i*DATA_W +: DATA_W], "R10",
                longint'(scan_data[i*DATA_W +: DATA_W]), longint'(e[i*DATA_W +: DATA_W]));
        end
      end
      // R3
      if (prev_pd && !adc_pd) begin
        settle_arm = 1; settle_t = 0; exp_next = 0;
      end else if (settle_arm) begin
        settle_t++;
        if (adc_sel != '0) begin
          chk(settle_t == int'(pwrup_cycles) + 1, "R3", settle_t, int'(pwrup_cycles) + 1);
          settle_arm = 0;
        end
      end
      // R6
      if (!prev_pd && adc_pd && low_power && enable) begin
        sleep_arm = 1; sleep_t = 0;
      end else if (sleep_arm) begin
        sleep_t++;
        if (!adc_pd) begin
          chk(sleep_t == ((sleep_cycles == 0) ? 1 : int'(sleep_cycles)), "R6",
              sleep_t, (sleep_cycles == 0) ? 1 : int'(sleep_cycles));
          sleep_arm = 0;
        end
      end
      // R7
      if (low_power && prev_sel[NUM_CH-1] && !adc_sel[NUM_CH-1]) begin
        lp_arm = 1; lp_t = 0;
      end else if (lp_arm) begin
        lp_t++;
        if (adc_pd) begin
          chk(lp_t >= 1 && lp_t <= 4, "R7", lp_t, 1);
          lp_arm = 0;
        end else if (lp_t > 4) begin
          chk(0, "R7", lp_t, 1);
          lp_arm = 0;
        end
      end
      // R4
      if (prev_sel != '0 && adc_sel != prev_sel) begin
        chk(prev_valid, "R4", prev_valid, 1);
        chk(adc_sel == '0, "R4", longint'(adc_sel), 0);
      end
      // R5
      if (prev_sel == '0 && adc_sel != '0) begin
        chk(adc_sel == NUM_CH'(1 << exp_next), "R5", longint'(adc_sel), longint'(1 << exp_next));
        exp_next = (exp_next + 1) % NUM_CH;
      end
      // R8
      if (!low_power && prev_en && enable && !prev_pd && adc_pd) chk(0, "R8", 1, 0);
      prev_sel = adc_sel; prev_pd = adc_pd; prev_valid = adc_valid;
      prev_done = scan_done; prev_en = enable;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    rst = 1'b0;
  endtask

  task automatic wait_scans(input int n, input string req);
    int target = done_seen + n;
    int guard = 0;
    while (done_seen < target && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_seen >= target, req, done_seen, target);
  endtask

  task automatic lp_phase(input int pw, input int sl);
    do_reset();
    low_power = 1'b1;
    pwrup_cycles = CNT_W'(pw);
    sleep_cycles = CNT_W'(sl);
    enable = 1'b1;
    wait_scans(3, "R6");
  endtask

  initial begin
    do_reset();
    #2;
    // R1
    chk(adc_pd == 1'b1, "R1", adc_pd, 1);
    chk(adc_sel == '0, "R1", longint'(adc_sel), 0);
    chk(scan_done == 1'b0, "R1", scan_done, 0);
    chk(scan_data == '0, "R1", longint'(scan_data[31:0]), 0);
    repeat (6) @(negedge clk);
    #2;
    chk(adc_pd == 1'b1 && adc_sel == '0, "R1", adc_pd, 1);

    lp_phase(3, 6);
    lp_phase(0, 1);
    lp_phase(2, 0);

    // R8: continuous mode, then stop through enable (R11)
    do_reset();
    low_power = 1'b0;
    pwrup_cycles = 8'd5;
    enable = 1'b1;
    wait_scans(4, "R8");
    @(negedge clk);
    enable = 1'b0;
    begin
      int g = 0;
      while (!adc_pd && g < 200) begin @(negedge clk); g++; end
      chk(adc_pd == 1'b1, "R11", adc_pd, 1);
    end
    repeat (10) @(negedge clk);
    #2;
    chk(adc_pd == 1'b1, "R11", adc_pd, 1);
    chk(adc_sel == '0, "R11", longint'(adc_sel), 0);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule